// File: doc/BRIEF.md
# SMBus Master Byte-Frame Controller

This block is a byte-at-a-time master engine for a two-wire SMBus/I2C bus, meant to sit behind a small CPU register interface. Software asks for a START, then writes a first byte holding a 7-bit target address and a direction bit. After that it moves data one byte per interrupt. For a write it loads the next byte before clearing the interrupt. For a read it clears the interrupt without loading anything. To end the transfer it raises a stop request. The block pulls SCL and SDA low through open-drain enables and advances the bus by one half bit period on each tick of an internal clock divider.

A byte-complete interrupt marks the end of every frame, the address frame included. Its position depends on the role. When the block transmits, the interrupt comes after the ACK clock. When it receives with the hardware-ACK enable set, the block drives the ACK bit itself and the interrupt also comes after the ACK clock. When it receives with that enable clear, the interrupt comes after the eighth data bit. The block then raises an ACK-request flag and waits for software to supply the ACK bit. While the interrupt is pending, SCL is held low.

Two status bits, `master` and `txmode`, report the role. Their four combinations are master transmitter, master receiver, slave transmitter and slave receiver. After reset, a STOP or a lost arbitration, the role is slave receiver.

The controller is a seven-state machine:
- IDLE: bus released.
- START: SCL released, SDA low.
- WAIT: both lines low while software acts.
- BIT: eight data bits, each a low phase followed by a high phase.
- ACKHOLD: SCL low while software decides the ACK of a received byte.
- ACK: the ninth clock.
- STOP: SCL released, SDA still low.

The transitions are:
- IDLE to START on a tick with a start request pending.
- START to WAIT on the next tick.
- WAIT to STOP on a tick with no interrupt pending and a stop request pending.
- WAIT to BIT on a tick with no interrupt pending and either a loaded byte or a receive request.
- BIT to IDLE when arbitration is lost.
- BIT to ACK after the last bit when transmitting, or when receiving with hardware ACK.
- BIT to ACKHOLD after the last bit when receiving with software ACK.
- ACKHOLD to ACK once the interrupt is cleared.
- ACK to WAIT after its high phase.
- STOP to IDLE on the next tick.

Top module: `smb_byte_master`

## Requirements
- R1: After reset, SCL and SDA are released (`scl_lo`=0, `sda_lo`=0), `irq`, `ack_rq` and `arb_lost` are 0, and the role is slave receiver (`master`=0, `txmode`=0).
- R2: A `start_req` pulse in idle produces a START: SDA falls while SCL is high. `master` rises with `txmode`=1 and stays 1 until a STOP is produced or arbitration is lost.
- R3: The first byte after START is sent MSB first. If its bit 0 is 1 (read), the role is master receiver once that frame's interrupt is raised. If bit 0 is 0 (write), the role stays master transmitter.
- R4: As a transmitter, `irq` rises after the ninth (ACK) SCL high phase, whatever `hw_ack_en` is. `ack_rx` then holds 1 if SDA was low in that phase (acknowledged) and 0 otherwise.
- R5: While `irq` is 1, SCL is held low and no SCL rising edge occurs.
- R6: If software clears `irq` after a master-transmitter interrupt without writing `dat_in`, the next frame is received: `txmode` becomes 0 and SDA is released during its data bits.
- R7: Receiving with `hw_ack_en`=0, `irq` and `ack_rq` rise after the eighth SCL high phase and before the ACK clock. After `irq` is cleared, the ACK clock drives SDA low if the last `ack_wr` wrote `ack_val`=1 (ACK) and releases it if it wrote 0 (NACK).
- R8: Receiving with `hw_ack_en`=1, the block drives the ACK bit from the stored `ack_val` without raising `ack_rq`, and `irq` rises after the ACK clock.
- R9: A received byte is assembled MSB first and is present on `rx_data` when that frame's `irq` is 1.
- R10: A `stop_req` followed by an interrupt clear produces a STOP (SDA rises while SCL is high). `master` then falls with both lines released.
- R11: While transmitting a 1, if SDA is sampled low during SCL high, `arb_lost` becomes 1, `master` and `txmode` become 0 and both lines are released. `arb_lost` stays set until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_req | input | 1 | One-cycle request for a START (honoured in idle) |
| stop_req | input | 1 | One-cycle request to end the transfer with a STOP |
| dat_wr | input | 1 | One-cycle write of `dat_in` as the next byte to send |
| dat_in | input | BYTE_W | Byte to send |
| irq_clr | input | 1 | One-cycle clear of the byte interrupt |
| ack_wr | input | 1 | One-cycle write of `ack_val` |
| ack_val | input | 1 | ACK bit to give as receiver, 1 = acknowledge |
| hw_ack_en | input | 1 | 1 = block drives receiver ACK itself |
| sda_in | input | 1 | Sampled level of the SDA line |
| scl_lo | output | 1 | 1 = pull SCL low |
| sda_lo | output | 1 | 1 = pull SDA low |
| irq | output | 1 | Byte-complete interrupt flag |
| ack_rq | output | 1 | Software must supply the ACK bit |
| ack_rx | output | 1 | ACK received from the slave, 1 = acknowledged |
| master | output | 1 | Role bit: 1 = master |
| txmode | output | 1 | Role bit: 1 = transmitter |
| arb_lost | output | 1 | Arbitration was lost |
| rx_data | output | BYTE_W | Last received byte |

## Verification
Some rules are checked by the assertions on every cycle:
- SCL is low whenever the interrupt is pending.
- A rising ACK request comes only from a software-ACK receiver with its interrupt raised.
- `master` rises only in the START shape and falls only with the bus released.
- A lost arbitration never coexists with master status.

Other behaviour only shows in the bench's scenarios, with a behavioural slave on the wires:
- where the interrupt falls within the nine-clock frame for each role and ACK setting;
- the direction-bit and no-reload switches into receiver role;
- the ACK and NACK bits the slave sees;
- the bytes moved in each direction;
- arbitration loss against a line held low.

// File: rtl/smb_pkg.sv
package smb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_WAIT,
        ST_BIT,
        ST_ACKHOLD,
        ST_ACK,
        ST_STOP
    } smb_st_e;

endpackage

// File: rtl/smb_tick.sv
module smb_tick #(
    parameter int DIV = 125
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] TOP = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (cnt == TOP)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == TOP);
endmodule

// File: rtl/smb_fsm.sv
module smb_fsm
    import smb_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              start_req,
    input  logic              stop_req,
    input  logic              dat_wr,
    input  logic [BYTE_W-1:0] dat_in,
    input  logic              irq_clr,
    input  logic              ack_wr,
    input  logic              ack_val,
    input  logic              hw_ack_en,
    input  logic              sda_i,
    output logic              scl_lo,
    output logic              sda_lo,
    output logic              irq,
    output logic              ack_rq,
    output logic              ack_rx,
    output logic              master,
    output logic              txmode,
    output logic              arb_lost,
    output logic [BYTE_W-1:0] rx_data
);
    localparam int CNT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    smb_st_e st, nx;
    logic              ph;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] sh, txbuf;
    logic start_pend, stop_pend, loaded, rx_arm, first, dir_rd, late_irq, ack_bit;
    logic arb_hit, half_end;

    assign arb_hit  = txmode && sh[BYTE_W-1] && !sda_i;
    assign half_end = tick && ph;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nx;
    end

    // next state
    always_comb begin
        nx = st;
        unique case (st)
            ST_IDLE:    if (tick && start_pend) nx = ST_START;
            ST_START:   if (tick) nx = ST_WAIT;
            ST_WAIT: begin
                if (tick && !irq) begin
                    if (stop_pend)            nx = ST_STOP;
                    else if (loaded || rx_arm) nx = ST_BIT;
                end
            end
            ST_BIT: begin
                if (half_end) begin
                    if (arb_hit)           nx = ST_IDLE;
                    else if (cnt == LAST)  nx = (txmode || hw_ack_en) ? ST_ACK : ST_ACKHOLD;
                end
            end
            ST_ACKHOLD: if (tick && !irq) nx = ST_ACK;
            ST_ACK:     if (half_end) nx = ST_WAIT;
            ST_STOP:    if (tick) nx = ST_IDLE;
            default:    nx = ST_IDLE;
        endcase
    end

    // bus outputs
    always_comb begin
        scl_lo = 1'b0;
        sda_lo = 1'b0;
        unique case (st)
            ST_IDLE:    begin scl_lo = 1'b0; sda_lo = 1'b0; end
            ST_START:   begin scl_lo = 1'b0; sda_lo = 1'b1; end
            ST_WAIT:    begin scl_lo = 1'b1; sda_lo = 1'b1; end
            ST_BIT:     begin scl_lo = !ph;  sda_lo = txmode ? !sh[BYTE_W-1] : 1'b0; end
            ST_ACKHOLD: begin scl_lo = 1'b1; sda_lo = 1'b0; end
            ST_ACK:     begin scl_lo = !ph;  sda_lo = txmode ? 1'b0 : ack_bit; end
            ST_STOP:    begin scl_lo = 1'b0; sda_lo = 1'b1; end
            default:    begin scl_lo = 1'b0; sda_lo = 1'b0; end
        endcase
    end

    // datapath and status
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph <= 1'b0; cnt <= '0; sh <= '0; txbuf <= '0;
            start_pend <= 1'b0; stop_pend <= 1'b0; loaded <= 1'b0; rx_arm <= 1'b0;
            first <= 1'b0; dir_rd <= 1'b0; late_irq <= 1'b0; ack_bit <= 1'b1;
            irq <= 1'b0; ack_rq <= 1'b0; ack_rx <= 1'b0; master <= 1'b0;
            txmode <= 1'b0; arb_lost <= 1'b0; rx_data <= '0;
        end else begin
            if (tick) ph <= (nx == st) ? ~ph : 1'b0;
            if (ack_wr) ack_bit <= ack_val;
            if (start_req && st == ST_IDLE) start_pend <= 1'b1;
            if (stop_req && master) stop_pend <= 1'b1;
            if (dat_wr && master) begin
                txbuf  <= dat_in;
                loaded <= 1'b1;
            end
            if (irq_clr && irq) begin
                irq <= 1'b0;
                if (!loaded && !dat_wr) begin
                    rx_arm <= 1'b1;
                    txmode <= 1'b0;
                end
            end
            if (st == ST_IDLE && nx == ST_START) begin
                start_pend <= 1'b0; stop_pend <= 1'b0;
                master <= 1'b1; txmode <= 1'b1; arb_lost <= 1'b0; first <= 1'b1;
            end
            if (st == ST_WAIT && nx == ST_BIT) begin
                sh     <= loaded ? txbuf : '1;
                txmode <= loaded;
                loaded <= 1'b0;
                rx_arm <= 1'b0;
                cnt    <= '0;
                if (first) dir_rd <= txbuf[0];
            end
            if (st == ST_BIT && half_end) begin
                sh  <= {sh[BYTE_W-2:0], sda_i};
                cnt <= cnt + 1'b1;
                if (arb_hit) begin
                    arb_lost <= 1'b1; master <= 1'b0; txmode <= 1'b0;
                    loaded <= 1'b0; rx_arm <= 1'b0; stop_pend <= 1'b0;
                end else if (cnt == LAST) begin
                    late_irq <= txmode || hw_ack_en;
                    if (!txmode) rx_data <= {sh[BYTE_W-2:0], sda_i};
                    if (!txmode && !hw_ack_en) begin
                        irq    <= 1'b1;
                        ack_rq <= 1'b1;
                    end
                end
            end
            if (st == ST_ACKHOLD && nx == ST_ACK) ack_rq <= 1'b0;
            if (st == ST_ACK && half_end) begin
                if (txmode) ack_rx <= !sda_i;
                if (late_irq) irq <= 1'b1;
                if (first) begin
                    first <= 1'b0;
                    if (dir_rd) txmode <= 1'b0;
                end
            end
            if (st == ST_STOP && tick) begin
                master <= 1'b0; txmode <= 1'b0; rx_arm <= 1'b0;
                loaded <= 1'b0; stop_pend <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/smb_byte_master.sv
module smb_byte_master #(
    parameter int CLK_DIV = 125,
    parameter int BYTE_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic              stop_req,
    input  logic              dat_wr,
    input  logic [BYTE_W-1:0] dat_in,
    input  logic              irq_clr,
    input  logic              ack_wr,
    input  logic              ack_val,
    input  logic              hw_ack_en,
    input  logic              sda_in,
    output logic              scl_lo,
    output logic              sda_lo,
    output logic              irq,
    output logic              ack_rq,
    output logic              ack_rx,
    output logic              master,
    output logic              txmode,
    output logic              arb_lost,
    output logic [BYTE_W-1:0] rx_data
);
    logic tick;

    smb_tick #(.DIV(CLK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    smb_fsm #(.BYTE_W(BYTE_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .start_req(start_req), .stop_req(stop_req),
        .dat_wr(dat_wr), .dat_in(dat_in), .irq_clr(irq_clr),
        .ack_wr(ack_wr), .ack_val(ack_val), .hw_ack_en(hw_ack_en),
        .sda_i(sda_in), .scl_lo(scl_lo), .sda_lo(sda_lo),
        .irq(irq), .ack_rq(ack_rq), .ack_rx(ack_rx),
        .master(master), .txmode(txmode), .arb_lost(arb_lost),
        .rx_data(rx_data)
    );
endmodule

// File: rtl/smb_byte_master_chk.sv
module smb_byte_master_chk (
    input logic clk,
    input logic rst_n,
    input logic irq,
    input logic scl_lo,
    input logic sda_lo,
    input logic ack_rq,
    input logic hw_ack_en,
    input logic master,
    input logic txmode,
    input logic arb_lost
);
    // R5: a pending interrupt stalls the bus with SCL low
    a_r5_scl_held: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> scl_lo);

    // R7: an ACK request appears only as a receiver with its interrupt up
    a_r7_ackrq_pre_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_rq) |-> (irq && !txmode && scl_lo));

    // R8: hardware ACK never asks software for the bit
    a_r8_hwack_no_rq: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_rq) |-> !hw_ack_en);

    // R2: master status begins in the START shape, as transmitter
    a_r2_start_shape: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(master) |-> (!scl_lo && sda_lo && txmode));

    // R10: leaving master status leaves the bus released
    a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(master) |-> (!scl_lo && !sda_lo));

    // R11: a lost arbitration excludes master status
    a_r11_arb_not_master: assert property (@(posedge clk) disable iff (!rst_n)
        arb_lost |-> !master);

    // R1: outside master status the role is slave receiver
    a_r1_slave_rx: assert property (@(posedge clk) disable iff (!rst_n)
        !master |-> !txmode);
endmodule

bind smb_byte_master smb_byte_master_chk u_chk (
    .clk(clk), .rst_n(rst_n), .irq(irq), .scl_lo(scl_lo), .sda_lo(sda_lo),
    .ack_rq(ack_rq), .hw_ack_en(hw_ack_en), .master(master),
    .txmode(txmode), .arb_lost(arb_lost)
);

// File: tb/tb_smb_byte_master.sv
`timescale 1ns/1ps
module tb_smb_byte_master;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_req = 0, stop_req = 0, dat_wr = 0, irq_clr = 0, ack_wr = 0, ack_val = 0, hw_ack_en = 0;
    logic [7:0] dat_in = '0;
    logic scl_lo, sda_lo, irq, ack_rq, ack_rx, master, txmode, arb_lost;
    logic [7:0] rx_data;
    logic s_lo = 0, rogue = 0;
    logic scl_b, sda_b;

    assign scl_b = !scl_lo;
    assign sda_b = !(sda_lo || s_lo || rogue);

    always #2.5 clk = ~clk;

    smb_byte_master #(.CLK_DIV(4), .BYTE_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .stop_req(stop_req),
        .dat_wr(dat_wr), .dat_in(dat_in), .irq_clr(irq_clr), .ack_wr(ack_wr),
        .ack_val(ack_val), .hw_ack_en(hw_ack_en), .sda_in(sda_b),
        .scl_lo(scl_lo), .sda_lo(sda_lo), .irq(irq), .ack_rq(ack_rq),
        .ack_rx(ack_rx), .master(master), .txmode(txmode),
        .arb_lost(arb_lost), .rx_data(rx_data)
    );

    int total = 0, bad = 0;

    // behavioural slave and bus observer
    logic [7:0] got[$];
    logic [7:0] rdq[$];
    bit m_acks[$];
    bit in_xfer = 0, exp_master = 0, addr_phase = 0, rd = 0, nacked = 0, slave_ack = 1, chk_en = 0;
    logic p_scl = 1, p_sda = 1;
    logic [7:0] shb = '0, cur = '0;
    int bitn = 0, rises = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        logic cs, ds;
        cs = scl_b;
        ds = sda_b;
        if (rst_n) begin
            if (p_scl && cs && p_sda && !ds) begin
                in_xfer = 1; exp_master = 1; bitn = 0; rises = 0;
                addr_phase = 1; rd = 0; nacked = 0; s_lo = 0; m_acks.delete();
            end else if (p_scl && cs && !p_sda && ds) begin
                in_xfer = 0; exp_master = 0; s_lo = 0;
            end else if (!p_scl && cs && in_xfer) begin
                rises++;
                if (bitn < 8) shb = {shb[6:0], ds};
                bitn++;
                if (bitn == 8) begin
                    if (addr_phase) begin rd = shb[0]; got.push_back(shb); end
                    else if (!rd) got.push_back(shb);
                end
                if (bitn == 9 && rd && !addr_phase) m_acks.push_back(!ds);
            end else if (p_scl && !cs && in_xfer) begin
                if (bitn == 8) begin
                    s_lo = (addr_phase || !rd) ? slave_ack : 1'b0;
                end else if (bitn == 9) begin
                    bitn = 0;
                    if (addr_phase) begin
                        addr_phase = 0;
                        if (rd) begin
                            cur = (rdq.size() > 0) ? rdq.pop_front() : 8'hFF;
                            s_lo = !cur[7];
                        end else s_lo = 0;
                    end else if (rd && !nacked && m_acks.size() > 0 && m_acks[m_acks.size()-1]) begin
                        cur = (rdq.size() > 0) ? rdq.pop_front() : 8'hFF;
                        s_lo = !cur[7];
                    end else begin
                        if (rd) nacked = 1;
                        s_lo = 0;
                    end
                end else if (bitn >= 1 && bitn <= 7 && rd && !addr_phase && !nacked) begin
                    s_lo = !cur[7-bitn];
                end
            end
            if (chk_en) begin
                chk("R2/R10 per-clock master", {31'd0, master}, {31'd0, exp_master});
                chk("R5 per-clock scl low under irq", {31'd0, irq && cs}, 32'd0);
            end
        end
        p_scl = cs;
        p_sda = ds;
    end

    task automatic step; @(negedge clk); #1; endtask
    task automatic wr_byte(input logic [7:0] b); dat_in = b; dat_wr = 1; step(); dat_wr = 0; endtask
    task automatic clr; irq_clr = 1; step(); irq_clr = 0; endtask
    task automatic set_ack(input logic v); ack_val = v; ack_wr = 1; step(); ack_wr = 0; endtask
    task automatic do_start; start_req = 1; step(); start_req = 0; endtask
    task automatic do_stop; stop_req = 1; step(); stop_req = 0; endtask

    task automatic wait_irq(input string tag, output int pos);
        int n = 0;
        while (!irq && n < 3000) begin step(); n++; end
        if (!irq) chk({tag, " irq timeout"}, 32'd0, 32'd1);
        pos = rises % 9;
    endtask

    task automatic wait_master(input string tag, input logic v);
        int n = 0;
        while (master !== v && n < 3000) begin step(); n++; end
        chk({tag, " master level"}, {31'd0, master}, {31'd0, v});
    endtask

    initial begin
        int pos;
        repeat (5) step();
        // R1 reset state
        chk("R1 scl_lo", {31'd0, scl_lo}, 0);
        chk("R1 sda_lo", {31'd0, sda_lo}, 0);
        chk("R1 irq/ack_rq/arb", {29'd0, irq, ack_rq, arb_lost}, 0);
        chk("R1 role", {30'd0, master, txmode}, 0);
        rst_n = 1;
        repeat (3) step();
        chk("R1 role after release", {30'd0, master, txmode}, 0);
        chk_en = 1;

        // write transfer, software ACK mode
        hw_ack_en = 0; slave_ack = 1; got.delete();
        do_start();
        wait_master("R2", 1);
        chk("R2 txmode", {31'd0, txmode}, 1);
        step();
        chk("R2 START seen on bus", {31'd0, in_xfer}, 1);
        wr_byte(8'hA4);
        wait_irq("R4 addr", pos);
        chk("R4 addr irq after ack", pos, 0);
        chk("R3 write keeps transmitter", {31'd0, txmode}, 1);
        chk("R4 ack_rx acked", {31'd0, ack_rx}, 1);
        chk("R3 addr byte seen", got.size() > 0 ? got[0] : 32'hX, 8'hA4);
        repeat (20) step();
        chk("R5 scl held with irq", {31'd0, scl_lo}, 1);
        wr_byte(8'h3C); clr();
        wait_irq("R4 data", pos);
        chk("R4 data irq after ack hw off", pos, 0);
        chk("R4 data byte seen", got.size() > 1 ? got[1] : 32'hX, 8'h3C);
        chk("R4 ack_rq stays 0 as tx", {31'd0, ack_rq}, 0);
        hw_ack_en = 1; slave_ack = 0;
        wr_byte(8'h55); clr();
        wait_irq("R4 nack", pos);
        chk("R4 irq after ack hw on", pos, 0);
        chk("R4 ack_rx nack", {31'd0, ack_rx}, 0);
        slave_ack = 1;
        do_stop(); clr();
        wait_master("R10", 0);
        step();
        chk("R10 STOP seen on bus", {31'd0, in_xfer}, 0);
        chk("R10 lines released", {30'd0, scl_lo, sda_lo}, 0);

        // read transfer, software ACK
        hw_ack_en = 0; rdq.delete(); rdq.push_back(8'hC3); rdq.push_back(8'h5A);
        repeat (10) step();
        do_start(); wait_master("R2 read", 1);
        wr_byte(8'hA5);
        wait_irq("R3 read addr", pos);
        chk("R3 read addr switches to receiver", {31'd0, txmode}, 0);
        clr();
        wait_irq("R7 b0", pos);
        chk("R7 irq before ack clock", pos, 8);
        chk("R7 ack_rq raised", {31'd0, ack_rq}, 1);
        chk("R9 rx byte0", rx_data, 8'hC3);
        set_ack(1); clr();
        wait_irq("R7 b1", pos);
        chk("R7 second irq before ack", pos, 8);
        chk("R7 slave saw ACK", m_acks.size() > 0 ? m_acks[0] : 32'hX, 1);
        chk("R9 rx byte1", rx_data, 8'h5A);
        set_ack(0); do_stop(); clr();
        wait_master("R10 read", 0);
        chk("R7 slave saw NACK", m_acks.size() > 1 ? m_acks[1] : 32'hX, 0);
        chk("R7 ack_rq cleared", {31'd0, ack_rq}, 0);

        // read transfer, hardware ACK
        hw_ack_en = 1; rdq.delete(); rdq.push_back(8'h96); rdq.push_back(8'h0F);
        set_ack(1);
        repeat (10) step();
        do_start(); wait_master("R2 hw", 1);
        wr_byte(8'hA5);
        wait_irq("R8 addr", pos);
        clr();
        wait_irq("R8 b0", pos);
        chk("R8 irq after ack clock", pos, 0);
        chk("R8 no ack_rq", {31'd0, ack_rq}, 0);
        chk("R8 slave saw ACK", m_acks.size() > 0 ? m_acks[0] : 32'hX, 1);
        chk("R9 rx byte hw0", rx_data, 8'h96);
        set_ack(0); clr();
        wait_irq("R8 b1", pos);
        chk("R8 irq after ack clock b1", pos, 0);
        chk("R8 slave saw NACK", m_acks.size() > 1 ? m_acks[1] : 32'hX, 0);
        chk("R9 rx byte hw1", rx_data, 8'h0F);
        do_stop(); clr();
        wait_master("R10 hw", 0);

        // no reload after a transmit interrupt
        repeat (10) step();
        do_start(); wait_master("R6", 1);
        wr_byte(8'hA4);
        wait_irq("R6 addr", pos);
        wr_byte(8'h11); clr();
        wait_irq("R6 data", pos);
        chk("R6 still transmitter", {31'd0, txmode}, 1);
        set_ack(0); clr();
        wait_irq("R6 rx", pos);
        chk("R6 switched to receiver", {31'd0, txmode}, 0);
        chk("R6 master kept", {31'd0, master}, 1);
        chk("R6 sda released in data bits", rx_data, 8'hFF);
        do_stop(); clr();
        wait_master("R6 stop", 0);

        // arbitration loss
        repeat (10) step();
        chk_en = 0;
        do_start(); wait_master("R11", 1);
        rogue = 1;
        wr_byte(8'hA4);
        begin
            int n = 0;
            while (!arb_lost && n < 3000) begin step(); n++; end
        end
        chk("R11 arb_lost", {31'd0, arb_lost}, 1);
        chk("R11 master dropped", {31'd0, master}, 0);
        chk("R11 txmode dropped", {31'd0, txmode}, 0);
        chk("R11 lines released", {30'd0, scl_lo, sda_lo}, 0);
        repeat (10) step();
        chk("R11 arb_lost sticky", {31'd0, arb_lost}, 1);
        rogue = 0;
        repeat (5) step();
        chk_en = 1;
        repeat (5) step();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule